// File: doc/BRIEF.md
# Strided Vector Load Engine with Bank Busy Throttling

This block fetches one vector from a word-interleaved, multi-bank memory with a single command. A command supplies a base word address, a stride and an element count. The engine walks the addresses `base + i*stride` in index order, sends each one to the bank chosen by the low address bits, and delivers every returned word as an indexed write into the vector register buffer beside it.

Each bank needs a fixed recovery time after an access. The engine keeps one countdown per bank and holds an element back while its bank is still recovering. Strides that come back to a bank too soon therefore cost cycles. A counter exposes those cycles so software can choose between stride layouts. With a stride that shares no factor with the bank count, a full-length vector streams at one element per cycle.

Banks return data after a fixed latency. The engine carries the index and bank of each request down a matching delay line, so no tag travels through the memory. A one-cycle completion pulse follows the final write.

Top module: `vld_strided_load`

## Requirements
- R1: A `start` pulse is accepted only while the engine is idle. It captures `base`, `stride` and `vlen`. A `start` during a running command is ignored, and later changes on those three inputs have no effect on the running command.
- R2: Element i uses word address `(base + i*stride) mod 2^ADDR_W`. Its bank is the low log2(NBANK) address bits, and `bank_row` carries the remaining upper bits. A request drives exactly that bit of `bank_req` high.
- R3: After a request to a bank in cycle t, the next request to the same bank comes no earlier than cycle t+BUSY (BUSY=4 by default).
- R4: At most one element is requested per cycle, in increasing index order. A blocked element is retried in the very next cycle, and it issues in the first cycle its bank is free.
- R5: With an odd stride and 16 banks, a 64-element command finishes with `stall_cnt` equal to 0.
- R6: A stride of 0 is legal. Every element then targets one bank, and an n-element command ends with `stall_cnt` = (BUSY-1)*(n-1).
- R7: `stall_cnt` counts the cycles in which a pending element was held back by a busy bank. It clears when a command is accepted and holds its value between commands.
- R8: The data that the addressed bank presents LAT cycles after a request appears on `wr_data`, together with `wr_en` and `wr_idx` = i, exactly LAT+1 cycles after the request cycle.
- R9: `done` is high for exactly one cycle. That cycle is the one right after the final `wr_en`.
- R10: A command with `vlen` = 0 makes no requests and no writes. `done` pulses in the cycle after the command is accepted.
- R11: A `vlen` above MAXVL (64) is clamped to MAXVL elements.
- R12: While reset is held, and after it is released, `bank_req`, `wr_en` and `done` are 0 and `stall_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command pulse, sampled while idle |
| base | input | ADDR_W | Word address of element 0 |
| stride | input | ADDR_W | Word distance between consecutive elements |
| vlen | input | $clog2(MAXVL+1) | Element count, clamped to MAXVL |
| bank_req | output | NBANK | One-hot read request, one bit per bank |
| bank_row | output | ADDR_W-$clog2(NBANK) | Row address within the requested bank |
| bank_rdata | input | NBANK*DATA_W | Read data of all banks, bank b at bits [b*DATA_W +: DATA_W] |
| wr_en | output | 1 | Element write strobe |
| wr_idx | output | $clog2(MAXVL) | Element slot being written |
| wr_data | output | DATA_W | Element value being written |
| done | output | 1 | One-cycle completion pulse |
| stall_cnt | output | STALL_W | Cycles lost to busy banks in the current or last command |

## Verification
Two functions can fall in the same cycle: the issue of a new element and the write-back of an older one. At the bank level, a stall on one bank can also meet the expiry of another bank's countdown. Strides of 0, 2, 8 and odd values, together with clamped and wrapping addresses, keep requests and returns overlapping while stalls come and go. A behavioural model with its own per-bank countdowns and a queue of pending returns predicts every request bit, row, write, completion pulse and stall count on every clock. Any one-cycle slip in issue or return therefore shows up as a mismatch.

// File: rtl/vld_pkg.sv
package vld_pkg;
  // Sequencer phases: idle, issuing elements, waiting for outstanding returns
  typedef enum logic [1:0] {
    VS_IDLE  = 2'd0,
    VS_ISSUE = 2'd1,
    VS_DRAIN = 2'd2
  } vld_state_e;
endpackage

// File: rtl/vld_bank_timer.sv
module vld_bank_timer #(
  parameter int NBANK = 16,
  parameter int BUSY  = 4,
  localparam int BANK_W = $clog2(NBANK),
  localparam int CNT_W  = $clog2(BUSY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_en,
  input  logic [BANK_W-1:0] hit_bank,
  output logic [NBANK-1:0]  bank_free
);
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_ld;

    always_comb begin
      cnt_ld = hit_en && (hit_bank == BANK_W'(g));
      cnt_d  = cnt_q;
      if (cnt_ld)               cnt_d = CNT_W'(BUSY - 1);
      else if (cnt_q != '0)     cnt_d = cnt_q - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign bank_free[g] = (cnt_q == '0);
  end
endmodule

// File: rtl/vld_issue_ctrl.sv
module vld_issue_ctrl
  import vld_pkg::*;
#(
  parameter int NBANK   = 16,
  parameter int ADDR_W  = 16,
  parameter int MAXVL   = 64,
  parameter int STALL_W = 16,
  localparam int BANK_W = $clog2(NBANK),
  localparam int ROW_W  = ADDR_W - BANK_W,
  localparam int LEN_W  = $clog2(MAXVL + 1),
  localparam int IDX_W  = $clog2(MAXVL)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  base,
  input  logic [ADDR_W-1:0]  stride,
  input  logic [LEN_W-1:0]   vlen,
  input  logic [NBANK-1:0]   bank_free,
  input  logic               fin,
  output logic               issue,
  output logic [BANK_W-1:0]  issue_bank,
  output logic [ROW_W-1:0]   issue_row,
  output logic [IDX_W-1:0]   issue_idx,
  output logic               issue_last,
  output logic               zero_done,
  output logic [STALL_W-1:0] stall_cnt
);
  vld_state_e         st_q, st_d;
  logic [LEN_W-1:0]   len_q, len_d, cnt_q, cnt_d, len_in, cnt_inc;
  logic [ADDR_W-1:0]  addr_q, addr_d, strd_q, strd_d;
  logic [STALL_W-1:0] stl_q, stl_d;

  assign len_in     = (vlen > LEN_W'(MAXVL)) ? LEN_W'(MAXVL) : vlen;
  assign cnt_inc    = cnt_q + LEN_W'(1);
  assign issue_bank = addr_q[BANK_W-1:0];
  assign issue_row  = addr_q[ADDR_W-1:BANK_W];
  assign issue_idx  = cnt_q[IDX_W-1:0];
  assign issue_last = (cnt_inc == len_q);
  assign issue      = (st_q == VS_ISSUE) && bank_free[issue_bank];
  assign stall_cnt  = stl_q;

  always_comb begin
    st_d      = st_q;
    len_d     = len_q;
    cnt_d     = cnt_q;
    addr_d    = addr_q;
    strd_d    = strd_q;
    stl_d     = stl_q;
    zero_done = 1'b0;
    unique case (st_q)
      VS_IDLE: begin
        if (start) begin
          len_d  = len_in;
          cnt_d  = '0;
          addr_d = base;
          strd_d = stride;
          stl_d  = '0;
          if (len_in == '0) zero_done = 1'b1;
          else              st_d      = VS_ISSUE;
        end
      end
      VS_ISSUE: begin
        if (issue) begin
          cnt_d  = cnt_inc;
          addr_d = addr_q + strd_q;
          if (issue_last) st_d = VS_DRAIN;
        end else begin
          stl_d = stl_q + STALL_W'(1);
        end
      end
      VS_DRAIN: begin
        if (fin) st_d = VS_IDLE;
      end
      default: st_d = VS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= VS_IDLE;
      len_q  <= '0;
      cnt_q  <= '0;
      addr_q <= '0;
      strd_q <= '0;
      stl_q  <= '0;
    end else begin
      st_q   <= st_d;
      len_q  <= len_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      strd_q <= strd_d;
      stl_q  <= stl_d;
    end
  end
endmodule

// File: rtl/vld_return_pipe.sv
module vld_return_pipe #(
  parameter int NBANK  = 16,
  parameter int DATA_W = 32,
  parameter int MAXVL  = 64,
  parameter int LAT    = 2,
  localparam int BANK_W = $clog2(NBANK),
  localparam int IDX_W  = $clog2(MAXVL)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    issue,
  input  logic [BANK_W-1:0]       issue_bank,
  input  logic [IDX_W-1:0]        issue_idx,
  input  logic                    issue_last,
  input  logic                    zero_done,
  input  logic [NBANK*DATA_W-1:0] bank_rdata,
  output logic                    wr_en,
  output logic [IDX_W-1:0]        wr_idx,
  output logic [DATA_W-1:0]       wr_data,
  output logic                    fin,
  output logic                    done
);
  logic [LAT-1:0]    v_q;
  logic [BANK_W-1:0] b_q [LAT];
  logic [IDX_W-1:0]  i_q [LAT];
  logic [LAT-1:0]    l_q;
  logic              wen_q, wlast_q, done_q, done_d;
  logic [IDX_W-1:0]  widx_q;
  logic [DATA_W-1:0] wdat_q, rsel;

  // Delay line matching the fixed bank latency; one stage per cycle
  for (genvar k = 0; k < LAT; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q[0] <= 1'b0;
          b_q[0] <= '0;
          i_q[0] <= '0;
          l_q[0] <= 1'b0;
        end else begin
          v_q[0] <= issue;
          if (issue) begin
            b_q[0] <= issue_bank;
            i_q[0] <= issue_idx;
            l_q[0] <= issue_last;
          end
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q[k] <= 1'b0;
          b_q[k] <= '0;
          i_q[k] <= '0;
          l_q[k] <= 1'b0;
        end else begin
          v_q[k] <= v_q[k-1];
          if (v_q[k-1]) begin
            b_q[k] <= b_q[k-1];
            i_q[k] <= i_q[k-1];
            l_q[k] <= l_q[k-1];
          end
        end
      end
    end
  end

  assign rsel   = bank_rdata[b_q[LAT-1]*DATA_W +: DATA_W];
  assign fin    = wen_q && wlast_q;
  assign done_d = fin || zero_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen_q   <= 1'b0;
      wlast_q <= 1'b0;
      widx_q  <= '0;
      wdat_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      wen_q  <= v_q[LAT-1];
      done_q <= done_d;
      if (v_q[LAT-1]) begin
        wlast_q <= l_q[LAT-1];
        widx_q  <= i_q[LAT-1];
        wdat_q  <= rsel;
      end
    end
  end

  assign wr_en   = wen_q;
  assign wr_idx  = widx_q;
  assign wr_data = wdat_q;
  assign done    = done_q;
endmodule

// File: rtl/vld_strided_load.sv
module vld_strided_load #(
  parameter int NBANK   = 16,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int MAXVL   = 64,
  parameter int BUSY    = 4,
  parameter int LAT     = 2,
  parameter int STALL_W = 16,
  localparam int BANK_W = $clog2(NBANK),
  localparam int ROW_W  = ADDR_W - BANK_W,
  localparam int LEN_W  = $clog2(MAXVL + 1),
  localparam int IDX_W  = $clog2(MAXVL)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       base,
  input  logic [ADDR_W-1:0]       stride,
  input  logic [LEN_W-1:0]        vlen,
  output logic [NBANK-1:0]        bank_req,
  output logic [ROW_W-1:0]        bank_row,
  input  logic [NBANK*DATA_W-1:0] bank_rdata,
  output logic                    wr_en,
  output logic [IDX_W-1:0]        wr_idx,
  output logic [DATA_W-1:0]       wr_data,
  output logic                    done,
  output logic [STALL_W-1:0]      stall_cnt
);
  logic [1:0]        rs_q;
  logic              srst_n;
  logic [NBANK-1:0]  bank_free;
  logic              issue, issue_last, zero_done, fin;
  logic [BANK_W-1:0] issue_bank;
  logic [IDX_W-1:0]  issue_idx;

  // Reset asserts at once, releases after two clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  vld_issue_ctrl #(
    .NBANK(NBANK), .ADDR_W(ADDR_W), .MAXVL(MAXVL), .STALL_W(STALL_W)
  ) u_ctrl (
    .clk(clk), .rst_n(srst_n), .start(start), .base(base), .stride(stride),
    .vlen(vlen), .bank_free(bank_free), .fin(fin), .issue(issue),
    .issue_bank(issue_bank), .issue_row(bank_row), .issue_idx(issue_idx),
    .issue_last(issue_last), .zero_done(zero_done), .stall_cnt(stall_cnt)
  );

  vld_bank_timer #(.NBANK(NBANK), .BUSY(BUSY)) u_timer (
    .clk(clk), .rst_n(srst_n), .hit_en(issue), .hit_bank(issue_bank),
    .bank_free(bank_free)
  );

  vld_return_pipe #(
    .NBANK(NBANK), .DATA_W(DATA_W), .MAXVL(MAXVL), .LAT(LAT)
  ) u_ret (
    .clk(clk), .rst_n(srst_n), .issue(issue), .issue_bank(issue_bank),
    .issue_idx(issue_idx), .issue_last(issue_last), .zero_done(zero_done),
    .bank_rdata(bank_rdata), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .fin(fin), .done(done)
  );

  for (genvar g = 0; g < NBANK; g++) begin : g_req
    assign bank_req[g] = issue && (issue_bank == BANK_W'(g));
  end
endmodule

// File: rtl/vld_strided_load_chk.sv
module vld_strided_load_chk #(
  parameter int NBANK   = 16,
  parameter int BUSY    = 4,
  parameter int STALL_W = 16,
  localparam int GW = $clog2(BUSY + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NBANK-1:0]   bank_req,
  input logic               done,
  input logic [STALL_W-1:0] stall_cnt
);
  // R2/R4: one bank request per cycle at most
  a_r2_req_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_req));

  // R7: a cycle that issues is not a stall cycle
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_req) |=> $stable(stall_cnt));

  // R9: completion pulse lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: no request while completing
  a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bank_req == '0));

  // R3: spacing between requests to one bank, measured by a counter
  for (genvar g = 0; g < NBANK; g++) begin : g_gap
    logic [GW-1:0] gap_q;
    logic          seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gap_q  <= '0;
        seen_q <= 1'b0;
      end else if (bank_req[g]) begin
        gap_q  <= GW'(1);
        seen_q <= 1'b1;
      end else if (gap_q != GW'(BUSY)) begin
        gap_q  <= gap_q + GW'(1);
      end
    end
    a_r3_bank_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_req[g] && seen_q) |-> (gap_q >= GW'(BUSY)));
  end
endmodule

bind vld_strided_load vld_strided_load_chk #(
  .NBANK(NBANK), .BUSY(BUSY), .STALL_W(STALL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_req(bank_req), .done(done),
  .stall_cnt(stall_cnt)
);

// File: tb/vld_strided_load_tb_top.sv
`timescale 1ns/1ps
module vld_strided_load_tb_top;
  localparam int NB = 16, AW = 16, DW = 32, MVL = 64, BUSY = 4, LAT = 2;
  localparam int LW = 7, IW = 6, RW = 12, SW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] base = '0, stride = '0;
  logic [LW-1:0] vlen = '0;
  logic [NB-1:0] bank_req;
  logic [RW-1:0] bank_row;
  logic [NB*DW-1:0] bank_rdata;
  logic          wr_en, done;
  logic [IW-1:0] wr_idx;
  logic [DW-1:0] wr_data;
  logic [SW-1:0] stall_cnt;

  int total = 0, bad = 0, cyc = 0, wr_seen = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  vld_strided_load dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
    .vlen(vlen), .bank_req(bank_req), .bank_row(bank_row),
    .bank_rdata(bank_rdata), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .done(done), .stall_cnt(stall_cnt)
  );

  function automatic logic [31:0] memf(input int wa);
    return (wa * 32'h9E3779B1) ^ 32'h00C0FFEE;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---- fixed-latency bank model ----
  logic bq_v [LAT];
  int   bq_b [LAT];
  int   bq_r [LAT];
  always @(posedge clk) begin
    for (int k = LAT - 1; k > 0; k--) begin
      bq_v[k] <= bq_v[k-1];
      bq_b[k] <= bq_b[k-1];
      bq_r[k] <= bq_r[k-1];
    end
    bq_v[0] <= rst_n && (bank_req != '0);
    for (int b = 0; b < NB; b++) if (bank_req[b]) bq_b[0] <= b;
    bq_r[0] <= int'(bank_row);
  end
  always_comb begin
    for (int b = 0; b < NB; b++)
      bank_rdata[b*DW +: DW] = (bq_v[LAT-1] === 1'b1 && bq_b[LAT-1] == b)
                               ? memf(bq_r[LAT-1] * NB + b) : (32'hBAD00000 + b);
  end

  // ---- behavioural reference model ----
  int m_st = 0, m_len = 0, m_idx = 0, m_addr = 0, m_strd = 0, m_stall = 0, e = 0;
  int m_busy [NB];
  bit m_wr = 0, m_wlast = 0, m_done = 0;
  int m_widx = 0, m_wdata = 0;
  int q_due [$], q_idx [$], q_wa [$], q_last [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_stall = 0; m_wr = 0; m_done = 0; m_wlast = 0; e = 0;
      for (int b = 0; b < NB; b++) m_busy[b] = 0;
      q_due.delete(); q_idx.delete(); q_wa.delete(); q_last.delete();
    end else begin
      int bk;
      bit iss, fin, zst, nwr, nlast;
      int nidx, ndat;
      bk  = m_addr % NB;
      iss = (m_st == 1) && (m_busy[bk] == 0);
      fin = m_wr && m_wlast;
      zst = (m_st == 0) && start && (vlen == 0);
      nwr = 0; nidx = m_widx; ndat = m_wdata; nlast = m_wlast;
      if (q_due.size() > 0 && q_due[0] == e) begin
        nwr = 1; nidx = q_idx.pop_front(); ndat = memf(q_wa.pop_front());
        nlast = q_last.pop_front(); void'(q_due.pop_front());
      end
      for (int b = 0; b < NB; b++)
        if (iss && b == bk) m_busy[b] = BUSY - 1;
        else if (m_busy[b] > 0) m_busy[b]--;
      if (m_st == 0) begin
        if (start) begin
          m_len = (vlen > MVL) ? MVL : int'(vlen);
          m_idx = 0; m_addr = int'(base); m_strd = int'(stride); m_stall = 0;
          if (m_len != 0) m_st = 1;
        end
      end else if (m_st == 1) begin
        if (iss) begin
          q_due.push_back(e + LAT); q_idx.push_back(m_idx);
          q_wa.push_back(m_addr); q_last.push_back(m_idx + 1 == m_len);
          m_idx++; m_addr = (m_addr + m_strd) & 32'hFFFF;
          if (m_idx == m_len) m_st = 2;
        end else m_stall = (m_stall + 1) & 32'hFFFF;
      end else if (fin) m_st = 0;
      m_done = fin || zst;
      m_wr = nwr; m_widx = nidx; m_wdata = ndat; m_wlast = nlast;
      e++;
    end
  end

  // ---- per-cycle comparison, away from the active edge ----
  always @(negedge clk) begin
    if (cmp_on) begin
      int bk;
      logic [NB-1:0] xreq;
      bk = m_addr % NB;
      xreq = ((m_st == 1) && (m_busy[bk] == 0)) ? (NB'(1) << bk) : '0;
      chk(bank_req === xreq, "R4 bank_req", bank_req, xreq);
      if (xreq != '0) chk(bank_row === RW'(m_addr / NB), "R2 bank_row", bank_row, m_addr / NB);
      chk(wr_en === m_wr, "R8 wr_en", wr_en, m_wr);
      if (m_wr) begin
        chk(wr_idx === IW'(m_widx), "R8 wr_idx", wr_idx, m_widx);
        chk(wr_data === DW'(m_wdata), "R8 wr_data", wr_data, DW'(m_wdata));
      end
      chk(done === m_done, "R9 done", done, m_done);
      chk(stall_cnt === SW'(m_stall), "R7 stall_cnt", stall_cnt, m_stall);
      if (wr_en) wr_seen++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic launch(input int b, input int s, input int n);
    @(negedge clk);
    base = AW'(b); stride = AW'(s); vlen = LW'(n); start = 1'b1;
    wr_seen = 0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int g = 0;
    while (done !== 1'b1 && g < 3000) begin @(negedge clk); g++; end
    chk(g < 3000, tag, g, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bank_req === '0 && wr_en === 1'b0 && done === 1'b0 && stall_cnt === '0,
        "R12 reset outputs", {bank_req, wr_en, done}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(bank_req === '0 && wr_en === 1'b0 && stall_cnt === '0, "R12 after release", bank_req, 0);
    cmp_on = 1;

    // unit stride, full length
    launch(0, 1, 64); wait_done("R9 done unit stride");
    chk(wr_seen == 64, "R8 writes unit stride", wr_seen, 64);
    chk(stall_cnt == 0, "R5 stride 1 stalls", stall_cnt, 0);

    // odd stride, full length
    launch(16'h0123, 3, 64); wait_done("R9 done stride 3");
    chk(stall_cnt == 0, "R5 stride 3 stalls", stall_cnt, 0);

    // zero stride serialises on one bank
    launch(16'h0045, 0, 5); wait_done("R9 done stride 0");
    chk(stall_cnt == (BUSY - 1) * 4, "R6 stride 0 stalls", stall_cnt, (BUSY - 1) * 4);

    // stride 8 ping-pongs between two banks
    launch(16'h0200, 8, 10); wait_done("R9 done stride 8");
    chk(stall_cnt == 8, "R7 stride 8 stalls", stall_cnt, 8);

    // stride 2 sweeps eight banks
    launch(16'h0011, 2, 40); wait_done("R9 done stride 2");
    chk(wr_seen == 40, "R8 writes stride 2", wr_seen, 40);

    // address wrap at the address width
    launch(16'hFFF0, 16'h0007, 20); wait_done("R2 done wrap");
    chk(wr_seen == 20, "R2 writes wrap", wr_seen, 20);

    // zero length
    launch(16'h0300, 1, 0);
    chk(done === 1'b1, "R10 done after zero length", done, 1);
    repeat (6) @(negedge clk);
    chk(wr_seen == 0, "R10 no writes", wr_seen, 0);

    // clamp above maximum
    launch(16'h0400, 5, 100); wait_done("R11 done clamp");
    chk(wr_seen == MVL, "R11 clamped count", wr_seen, MVL);

    // start during a run is ignored
    launch(16'h0500, 1, 32);
    repeat (5) @(negedge clk);
    base = 16'h0777; stride = 16'h0009; vlen = 7'd3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done("R1 done");
    chk(wr_seen == 32, "R1 ignored start count", wr_seen, 32);
    repeat (6) @(negedge clk);
    chk(bank_req === '0 && wr_en === 1'b0, "R1 no extra command", bank_req, 0);

    repeat (4) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule